// File: doc/BRIEF.md
# Encrypted Region Access Router

This block sits on a memory request path, between the hosts and two cipher engines. It holds a small programmable table of address regions. Each region has a page-granular base, a page-granular limit, an enable flag and a security attribute. Each incoming request carries an address, a security bit and a host-group bit. For each request the block decides three things:

- whether the request goes down the encrypting path or the direct clear path;
- whether its security bit must be lowered to non-secure;
- which of the two cipher engines serves it.

The result is registered in a single output stage with a valid/ready handshake.

In normal mode the engine is chosen from the security bit after any rewrite, so each world always uses its own key. Software can instead set shared-key mode, where both engines hold the same key and the same security setting. In that mode requests are spread across the engines by host group, so the two groups run in parallel. The mode bit is driven on a port so that surrounding logic can check that configuration. The block never rejects a request. A non-secure request to a secure region is forwarded as non-secure, and a later access checker decides whether to deny it.

The output stage is a two-state machine:

- **ST_IDLE**: the output is empty.
- **ST_FULL**: the output holds one routed request.

Its transitions are:

- **LOAD** (ST_IDLE to ST_FULL): a request is accepted.
- **REFILL** (ST_FULL to ST_FULL): the held request leaves while a new one is accepted.
- **STALL** (ST_FULL to ST_FULL): the held request is not taken.
- **DRAIN** (ST_FULL to ST_IDLE): the held request leaves and nothing new arrives.
- **WAIT** (ST_IDLE to ST_IDLE): no request arrives.

Top module: `enc_region_router`

## Requirements
- R1: A request whose page number (address bits 31:12) is at least an enabled region's base page and at most its limit page is routed with `out_encrypt`=1. Disabled regions never match. The limit page is inclusive, up to byte offset 0xFFF.
- R2: A request that matches no enabled region is routed with `out_encrypt`=0, its security bit unchanged and `out_engine`=0.
- R3: When the matched region is non-secure (attribute bit1=0), `out_secure` is 0 even if `req_secure` was 1.
- R4: When the matched region is secure, the request's own security bit is passed through. A non-secure request to a secure region is still accepted and leaves with `out_encrypt`=1 and `out_secure`=0.
- R5: With shared mode off, an encrypted request goes to `out_engine`=0 (secure-key engine) when its rewritten security bit is 1, and to `out_engine`=1 (non-secure-key engine) when it is 0.
- R6: With shared mode on, an encrypted request from host group 0 goes to engine 0 and one from host group 1 goes to engine 1. `out_secure` still follows the region rewrite of R3 and R4.
- R7: `shared_mode` reflects bit0 of the last write with `cfg_field`=3.
- R8: When several enabled regions match, the one with the lowest index decides the security rewrite.
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on the outputs with `out_valid`=1 right after that edge.
- R10: While `out_valid`=1 and `out_ready`=0, `req_ready` is 0 and every output field stays unchanged.
- R11: A table write applies from the next clock edge on. A request accepted at the same edge as the write uses the old table, and a request already held in the output is not altered by later writes. Write fields are: `cfg_field` 0 = base (`cfg_wdata`[31:12]), 1 = limit (`cfg_wdata`[31:12]), 2 = attribute (bit0 enable, bit1 secure), 3 = mode (bit0).
- R12: After reset all regions are disabled, `shared_mode`=0, `out_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Region index for a write |
| cfg_field | input | 2 | Field select: 0 base, 1 limit, 2 attribute, 3 mode |
| cfg_wdata | input | 32 | Write data |
| shared_mode | output | 1 | Shared-key mode bit currently in force |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | 32 | Request address |
| req_secure | input | 1 | Request security bit (1 = secure) |
| req_host | input | 1 | Request host group |
| out_valid | output | 1 | Routed request valid |
| out_ready | input | 1 | Selected path can take the routed request |
| out_addr | output | 32 | Routed address |
| out_secure | output | 1 | Security bit after rewrite |
| out_encrypt | output | 1 | 1 = encrypting path, 0 = clear path |
| out_engine | output | 1 | Cipher engine: 0 secure-key, 1 non-secure-key |

## Verification
A corrupted table entry or a wrong priority pick shows up on the very next output beat. It appears as a wrong `out_encrypt` or `out_secure` value for an address whose region is known, so each check targets addresses just inside and just outside region edges, and overlaps. A stale mode bit shows on the port at once and, one cycle after acceptance, as an engine choice that disagrees with either the security bit or the host group. An output state machine stuck in the wrong state shows as `req_ready` high while a held beat is refused, or as held fields that change during a stall. Both are visible in the first stalled cycle.

// File: rtl/erar_pkg.sv
package erar_pkg;

    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LIMIT = 2'd1,
        CFG_ATTR  = 2'd2,
        CFG_MODE  = 2'd3
    } cfg_field_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FULL = 1'b1
    } route_state_e;

    localparam logic ENG_SECURE_KEY  = 1'b0;
    localparam logic ENG_NSECURE_KEY = 1'b1;

    localparam int ATTR_EN_BIT  = 0;
    localparam int ATTR_SEC_BIT = 1;

endpackage

// File: rtl/erar_region_table.sv
module erar_region_table
    import erar_pkg::*;
#(
    parameter int N_REG    = 8,
    parameter int ADDR_W   = 32,
    parameter int PAGE_SH  = 12,
    localparam int IDX_W   = $clog2(N_REG),
    localparam int PG_W    = ADDR_W - PAGE_SH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  cfg_field_e                  cfg_field,
    input  logic [ADDR_W-1:0]           cfg_wdata,
    output logic [N_REG-1:0][PG_W-1:0]  base_pg,
    output logic [N_REG-1:0][PG_W-1:0]  limit_pg,
    output logic [N_REG-1:0]            reg_en,
    output logic [N_REG-1:0]            reg_sec,
    output logic                        shared_mode
);

    logic [PG_W-1:0] wr_page;
    logic            unused_wdata;

    assign wr_page      = cfg_wdata[ADDR_W-1:PAGE_SH];
    assign unused_wdata = ^cfg_wdata[PAGE_SH-1:2];

    for (genvar g = 0; g < N_REG; g++) begin : g_region
        logic sel;
        assign sel = cfg_we && (cfg_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_pg[g]  <= '0;
                limit_pg[g] <= '0;
                reg_en[g]   <= 1'b0;
                reg_sec[g]  <= 1'b0;
            end else if (sel) begin
                unique case (cfg_field)
                    CFG_BASE:  base_pg[g]  <= wr_page;
                    CFG_LIMIT: limit_pg[g] <= wr_page;
                    CFG_ATTR: begin
                        reg_en[g]  <= cfg_wdata[ATTR_EN_BIT];
                        reg_sec[g] <= cfg_wdata[ATTR_SEC_BIT];
                    end
                    CFG_MODE: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shared_mode <= 1'b0;
        end else if (cfg_we && cfg_field == CFG_MODE) begin
            shared_mode <= cfg_wdata[0];
        end
    end

    // R7: a mode write is visible after exactly one edge
    p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_field == CFG_MODE |=> shared_mode == $past(cfg_wdata[0]));

    // R11: attribute write reaches the table on the following edge
    p_attr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_field == CFG_ATTR && cfg_idx == '0
        |=> reg_en[0] == $past(cfg_wdata[ATTR_EN_BIT]));

endmodule

// File: rtl/erar_region_match.sv
module erar_region_match #(
    parameter int N_REG    = 8,
    parameter int ADDR_W   = 32,
    parameter int PAGE_SH  = 12,
    localparam int IDX_W   = $clog2(N_REG),
    localparam int PG_W    = ADDR_W - PAGE_SH
) (
    input  logic [PG_W-1:0]             req_pg,
    input  logic [N_REG-1:0][PG_W-1:0]  base_pg,
    input  logic [N_REG-1:0][PG_W-1:0]  limit_pg,
    input  logic [N_REG-1:0]            reg_en,
    input  logic [N_REG-1:0]            reg_sec,
    output logic                        any_hit,
    output logic [IDX_W-1:0]            hit_idx,
    output logic                        hit_sec
);

    logic [N_REG-1:0] hit_vec;

    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        assign hit_vec[g] = reg_en[g] && (req_pg >= base_pg[g]) && (req_pg <= limit_pg[g]);
    end

    // lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        for (int i = N_REG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_sec = reg_sec[hit_idx];
    end

    // R8: the chosen region really matches and no lower one does
    always_comb begin
        if (any_hit) begin
            p_pick_valid_r8: assert (hit_vec[hit_idx]);
            for (int j = 0; j < N_REG; j++) begin
                if (j < int'(hit_idx)) begin
                    p_lowest_wins_r8: assert (!hit_vec[j]);
                end
            end
        end else begin
            p_no_hit_r2: assert (hit_vec == '0);
        end
    end

endmodule

// File: rtl/erar_route_fsm.sv
module erar_route_fsm
    import erar_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    input  logic              req_host,
    input  logic              any_hit,
    input  logic              hit_sec,
    input  logic              shared_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_secure,
    output logic              out_encrypt,
    output logic              out_engine
);

    route_state_e state_q, state_d;
    logic         accept;
    logic         sec_new;
    logic         eng_new;

    assign req_ready = (state_q == ST_IDLE) || out_ready;
    assign accept    = req_valid && req_ready;

    // rewrite: only a non-secure region forces the bit low
    assign sec_new = req_secure && !(any_hit && !hit_sec);

    always_comb begin
        if (!any_hit)         eng_new = ENG_SECURE_KEY;
        else if (shared_mode) eng_new = req_host;
        else                  eng_new = sec_new ? ENG_SECURE_KEY : ENG_NSECURE_KEY;
    end

    // next-state: LOAD, REFILL, STALL, DRAIN, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_FULL;
            ST_FULL: if (out_ready)  state_d = req_valid ? ST_FULL : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register: loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr    <= '0;
            out_secure  <= 1'b0;
            out_encrypt <= 1'b0;
            out_engine  <= 1'b0;
        end else if (accept) begin
            out_addr    <= req_addr;
            out_secure  <= sec_new;
            out_encrypt <= any_hit;
            out_engine  <= eng_new;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid && out_addr == $past(req_addr));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !req_ready);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_secure)
                                    && $stable(out_encrypt) && $stable(out_engine));

    p_clear_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !any_hit
        |=> !out_encrypt && !out_engine && out_secure == $past(req_secure));

    p_ns_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && any_hit && !hit_sec |=> out_encrypt && !out_secure);

    p_sec_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && any_hit && hit_sec |=> out_secure == $past(req_secure));

    p_engine_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && any_hit && !shared_mode |=> out_engine == !out_secure);

    p_engine_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && any_hit && shared_mode |=> out_engine == $past(req_host));

endmodule

// File: rtl/enc_region_router.sv
module enc_region_router
    import erar_pkg::*;
#(
    parameter int N_REG    = 8,
    parameter int ADDR_W   = 32,
    parameter int PAGE_SH  = 12,
    localparam int IDX_W   = $clog2(N_REG),
    localparam int PG_W    = ADDR_W - PAGE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              shared_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    input  logic              req_host,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_secure,
    output logic              out_encrypt,
    output logic              out_engine
);

    logic [N_REG-1:0][PG_W-1:0] base_pg;
    logic [N_REG-1:0][PG_W-1:0] limit_pg;
    logic [N_REG-1:0]           reg_en;
    logic [N_REG-1:0]           reg_sec;
    logic                       any_hit;
    logic [IDX_W-1:0]           hit_idx;
    logic                       hit_sec;
    logic                       unused_idx;

    assign unused_idx = ^hit_idx;

    erar_region_table #(
        .N_REG(N_REG), .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_field  (cfg_field_e'(cfg_field)),
        .cfg_wdata  (cfg_wdata),
        .base_pg    (base_pg),
        .limit_pg   (limit_pg),
        .reg_en     (reg_en),
        .reg_sec    (reg_sec),
        .shared_mode(shared_mode)
    );

    erar_region_match #(
        .N_REG(N_REG), .ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH)
    ) u_match (
        .req_pg  (req_addr[ADDR_W-1:PAGE_SH]),
        .base_pg (base_pg),
        .limit_pg(limit_pg),
        .reg_en  (reg_en),
        .reg_sec (reg_sec),
        .any_hit (any_hit),
        .hit_idx (hit_idx),
        .hit_sec (hit_sec)
    );

    erar_route_fsm #(
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_secure (req_secure),
        .req_host   (req_host),
        .any_hit    (any_hit),
        .hit_sec    (hit_sec),
        .shared_mode(shared_mode),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_addr   (out_addr),
        .out_secure (out_secure),
        .out_encrypt(out_encrypt),
        .out_engine (out_engine)
    );

    // R12: nothing leaves the block without a prior acceptance
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) && !out_valid |=> !out_valid);

endmodule

// File: tb/enc_region_router_tb.sv
module enc_region_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        shared_mode;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_secure = 1'b0;
    logic        req_host = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_secure;
    logic        out_encrypt;
    logic        out_engine;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    enc_region_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .shared_mode(shared_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_secure(req_secure), .req_host(req_host),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_secure(out_secure), .out_encrypt(out_encrypt), .out_engine(out_engine)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [1:0] fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // present one request with out_ready high; outputs valid at return
    task automatic send(input logic [31:0] a, input logic s, input logic h);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_secure = s; req_host = h;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic enc, input logic sec, input logic eng);
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " encrypt"}, 32'(out_encrypt), 32'(enc));
        chk({tag, " secure"}, 32'(out_secure), 32'(sec));
        chk({tag, " engine"}, 32'(out_engine), 32'(eng));
    endtask

    task automatic t_reset;
        chk("R12 out_valid", 32'(out_valid), 32'd0);
        chk("R12 req_ready", 32'(req_ready), 32'd1);
        chk("R12 shared_mode", 32'(shared_mode), 32'd0);
        send(32'h1000_0000, 1'b1, 1'b0);
        expect_out("R12 table empty", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_setup;
        wr(3'd0, 2'd0, 32'h1000_0000); wr(3'd0, 2'd1, 32'h1000_0000); wr(3'd0, 2'd2, 32'd3);
        wr(3'd1, 2'd0, 32'h2000_0000); wr(3'd1, 2'd1, 32'h2000_1000); wr(3'd1, 2'd2, 32'd1);
        wr(3'd2, 2'd0, 32'h1000_0000); wr(3'd2, 2'd1, 32'h1FFF_F000); wr(3'd2, 2'd2, 32'd1);
        wr(3'd3, 2'd0, 32'h3000_0000); wr(3'd3, 2'd1, 32'h3000_0000); wr(3'd3, 2'd2, 32'd2);
    endtask

    task automatic t_match;
        send(32'h1000_0FFC, 1'b1, 1'b0);
        expect_out("R1 R5 secure hit", 1'b1, 1'b1, 1'b0);
        chk("R9 addr", out_addr, 32'h1000_0FFC);
        send(32'h2000_1FFF, 1'b0, 1'b0);
        expect_out("R1 limit inclusive", 1'b1, 1'b0, 1'b1);
        send(32'h2000_2000, 1'b0, 1'b0);
        expect_out("R1 past limit", 1'b0, 1'b0, 1'b0);
        send(32'h0FFF_FFFF, 1'b1, 1'b0);
        expect_out("R1 below base", 1'b0, 1'b1, 1'b0);
        send(32'h3000_0000, 1'b1, 1'b0);
        expect_out("R1 disabled region", 1'b0, 1'b1, 1'b0);
        send(32'h4000_0000, 1'b1, 1'b1);
        expect_out("R2 clear path", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_rewrite;
        send(32'h2000_0010, 1'b1, 1'b0);
        expect_out("R3 forced non-secure", 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1000_0100; req_secure = 1'b0; req_host = 1'b0;
        #1 chk("R4 accepted", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_out("R4 ns to secure region", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_priority;
        send(32'h1000_0800, 1'b1, 1'b0);
        expect_out("R8 region0 wins", 1'b1, 1'b1, 1'b0);
        send(32'h1000_1000, 1'b1, 1'b0);
        expect_out("R8 region2 only", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_shared;
        wr(3'd0, 2'd3, 32'd1);
        chk("R7 mode on", 32'(shared_mode), 32'd1);
        send(32'h1000_0000, 1'b1, 1'b1);
        expect_out("R6 host1 secure", 1'b1, 1'b1, 1'b1);
        send(32'h2000_0000, 1'b1, 1'b0);
        expect_out("R6 host0 rewrite", 1'b1, 1'b0, 1'b0);
        send(32'h2000_0000, 1'b0, 1'b1);
        expect_out("R6 host1 ns", 1'b1, 1'b0, 1'b1);
        send(32'h4000_0000, 1'b1, 1'b1);
        expect_out("R6 R2 miss", 1'b0, 1'b1, 1'b0);
        wr(3'd0, 2'd3, 32'd0);
        chk("R7 mode off", 32'(shared_mode), 32'd0);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_field = 2'd2; cfg_wdata = 32'd3;
        req_valid = 1'b1; req_addr = 32'h3000_0004; req_secure = 1'b1; req_host = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_out("R11 same-edge old table", 1'b0, 1'b1, 1'b0);
        send(32'h3000_0004, 1'b0, 1'b0);
        expect_out("R11 new table", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h2000_0040; req_secure = 1'b1; req_host = 1'b0;
        @(negedge clk);
        req_addr = 32'h4000_0000; req_secure = 1'b1;
        chk("R10 ready low", 32'(req_ready), 32'd0);
        expect_out("R10 held A", 1'b1, 1'b0, 1'b1);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_field = 2'd2; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        chk("R10 addr stable", out_addr, 32'h2000_0040);
        expect_out("R11 R10 held after write", 1'b1, 1'b0, 1'b1);
        chk("R10 still stalled", 32'(req_ready), 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 B after release", out_addr, 32'h4000_0000);
        expect_out("R10 B routed", 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R9 drained", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_match();
        t_rewrite();
        t_priority();
        t_shared();
        t_write_timing();
        t_backpressure();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule